// File: doc/BRIEF.md
# Edge Capture Unit

This block timestamps transitions on three input pins. Each channel watches one pin and synchronizes it to the system clock. It accepts a new level only after that level has been seen on two consecutive clock edges. When the accepted level changes in the direction the channel is set up for, the channel copies the value of one of two free-running 16-bit timer buses into a small FIFO. The channel also raises its interrupt flag. The timers are generated outside this block and arrive as plain input buses.

Software uses a simple register port. Through it, software sets the edge mode, timer choice and interrupt enable of each channel. It can also inspect the fill level and overflow state of every FIFO, clear flags and overflow bits by writing ones, and pop captured values one at a time. Read data follows the address combinationally. A read strobe on a FIFO address removes the entry being returned on the following clock edge.

Top module: `ecap_top`

## Requirements
- R1: After reset, the control register, status register and flag register all read 0. The irq output is 0, and a FIFO read returns 0.
- R2: A pin level counts only once it has held across two rising clock edges after the two-stage synchronizer. A high pulse lasting one clock period is never captured, and a pulse lasting two clock periods is captured.
- R3: A pin change driven before rising edge E1 enters the FIFO on edge E4. The fill count is unchanged after E3 and incremented after E4.
- R4: Control register (address 0) bits [4n+1:4n] set the mode of channel n: 00 off, 01 rising, 10 falling, 11 both edges. A transition the mode excludes is not captured. The control register reads back what was written.
- R5: Control bit 4n+2 selects the time base of channel n. A 0 selects timer bus A and a 1 selects timer bus B, and the value stored is the selected bus value at the capture edge.
- R6: Each channel holds up to two entries. A read strobe at address 3+n returns the oldest entry of channel n and removes it. A read of an empty FIFO returns 0 and changes nothing.
- R7: A capture into a full FIFO drops the oldest entry, keeps the new one, leaves the count at 2 and sets the channel's overflow bit.
- R8: Status register (address 1) shows the entry count of channel n in bits [4n+1:4n] and its overflow bit at 4n+2. Writing 1 to an overflow bit clears it, and writing 0 leaves it.
- R9: Flag register (address 2) bit n is set by every capture of channel n and cleared by writing 1. irq[n] equals flag n ANDed with control bit 4n+3.
- R10: Channels are independent. Activity on one pin changes no other channel's FIFO, count, overflow bit or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_pin | input | 3 | Asynchronous capture inputs, one per channel |
| tmr_a | input | 16 | Timer bus A |
| tmr_b | input | 16 | Timer bus B |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| irq | output | 3 | Per-channel masked interrupt request |

## Verification
Assertions check the following on every cycle: the FIFO count bound, that overflow is set by a push into a full FIFO, that an empty pop has no effect, the shift on a pop, that an off channel stays silent, that a flag is set after each capture, interrupt masking, and control readback. The bench scenarios show the rest: the exact four-edge latency, rejection of one-cycle glitches, the value and order of captured timestamps, time-base selection, and independence between channels. None of these is visible to a single-cycle property.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    // Per-channel control nibble: ien at bit 3, tsel at bit 2, mode at [1:0]
    typedef struct packed {
        logic       ien;
        logic       tsel;
        edge_mode_e mode;
    } chan_cfg_t;

    localparam int CFG_W      = 4;
    localparam int ADDR_CTRL  = 0;
    localparam int ADDR_STAT  = 1;
    localparam int ADDR_FLAG  = 2;
    localparam int ADDR_FIFO0 = 3;
endpackage

// File: rtl/cap_qual.sv
module cap_qual
    import ecap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  edge_mode_e mode,
    output logic       event_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic hold;
        logic lvl;
    } qual_st_t;

    qual_st_t q_q, q_d;
    logic rise, fall;

    always_comb begin
        q_d      = q_q;
        q_d.s1   = pin;
        q_d.s2   = q_q.s1;
        q_d.hold = q_q.s2;
        if (q_q.s2 == q_q.hold) begin
            q_d.lvl = q_q.s2;
        end
        rise = q_d.lvl & ~q_q.lvl;
        fall = ~q_d.lvl & q_q.lvl;
        case (mode)
            EDGE_RISE: event_o = rise;
            EDGE_FALL: event_o = fall;
            EDGE_BOTH: event_o = rise | fall;
            default:   event_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    // R4: a disabled channel never reports an edge
    p_off_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == EDGE_OFF) |-> !event_o);

    // R2: an edge is only reported when the last two synced samples agree
    p_hold_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        event_o |-> (q_q.s2 == q_q.hold));
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic          ovf_clr,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt,
    output logic          ovf
);
    localparam int NXT = (DEPTH > 1) ? 1 : 0;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CW-1:0]           cnt;
        logic                    ovf;
    } fifo_st_t;

    fifo_st_t f_q, f_d;

    always_comb begin
        f_d = f_q;
        if (pop && (f_q.cnt != '0)) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                f_d.mem[i] = f_q.mem[i+1];
            end
            f_d.cnt = f_q.cnt - CW'(1);
        end
        if (ovf_clr) begin
            f_d.ovf = 1'b0;
        end
        if (push) begin
            if (f_d.cnt == CW'(DEPTH)) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    f_d.mem[i] = f_d.mem[i+1];
                end
                f_d.mem[DEPTH-1] = din;
                f_d.ovf          = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (f_d.cnt == CW'(i)) begin
                        f_d.mem[i] = din;
                    end
                end
                f_d.cnt = f_d.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign dout = (f_q.cnt != '0) ? f_q.mem[0] : '0;
    assign cnt  = f_q.cnt;
    assign ovf  = f_q.ovf;

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    p_full_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && cnt == CW'(DEPTH)) |=> (ovf && cnt == CW'(DEPTH)));

    p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt == '0) |=> (cnt == '0 && dout == '0));

    p_pop_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt == CW'(DEPTH)) |=> (dout == $past(f_q.mem[NXT])));
endmodule

// File: rtl/cap_chan.sv
module cap_chan
    import ecap_pkg::*;
#(
    parameter int TW    = 16,
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin,
    input  chan_cfg_t     cfg,
    input  logic [TW-1:0] tmr_a,
    input  logic [TW-1:0] tmr_b,
    input  logic          pop,
    input  logic          ovf_clr,
    input  logic          flag_clr,
    output logic [TW-1:0] dout,
    output logic [CW-1:0] cnt,
    output logic          ovf,
    output logic          flag,
    output logic          irq
);
    typedef struct packed {
        logic flag;
    } chan_st_t;

    chan_st_t c_q, c_d;
    logic          hit;
    logic [TW-1:0] stamp;

    cap_qual u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin     (pin),
        .mode    (cfg.mode),
        .event_o (hit)
    );

    assign stamp = cfg.tsel ? tmr_b : tmr_a;

    cap_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (hit),
        .din     (stamp),
        .pop     (pop),
        .ovf_clr (ovf_clr),
        .dout    (dout),
        .cnt     (cnt),
        .ovf     (ovf)
    );

    always_comb begin
        c_d = c_q;
        if (flag_clr) begin
            c_d.flag = 1'b0;
        end
        if (hit) begin
            c_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign flag = c_q.flag;
    assign irq  = c_q.flag & cfg.ien;

    p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.ien |-> !irq);
endmodule

// File: rtl/ecap_top.sv
module ecap_top
    import ecap_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int TW    = 16,
    parameter int DEPTH = 2,
    parameter int AW    = 3,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cap_pin,
    input  logic [TW-1:0]  tmr_a,
    input  logic [TW-1:0]  tmr_b,
    input  logic           reg_en,
    input  logic           reg_we,
    input  logic [AW-1:0]  reg_addr,
    input  logic [TW-1:0]  reg_wdata,
    output logic [TW-1:0]  reg_rdata,
    output logic [NCH-1:0] irq
);
    // Layout assumes NCH*CFG_W <= TW and CW <= 2 (status field: count, then overflow).
    typedef struct packed {
        chan_cfg_t [NCH-1:0] cfg;
    } top_st_t;

    top_st_t t_q, t_d;

    logic [NCH-1:0][TW-1:0] ch_dout;
    logic [NCH-1:0][CW-1:0] ch_cnt;
    logic [NCH-1:0]         ch_ovf;
    logic [NCH-1:0]         ch_flag;
    logic [NCH-1:0]         ch_pop;
    logic [NCH-1:0]         ch_ovf_clr;
    logic [NCH-1:0]         ch_flag_clr;

    logic wr_ctrl, wr_stat, wr_flag;

    assign wr_ctrl = reg_en && reg_we && (reg_addr == AW'(ADDR_CTRL));
    assign wr_stat = reg_en && reg_we && (reg_addr == AW'(ADDR_STAT));
    assign wr_flag = reg_en && reg_we && (reg_addr == AW'(ADDR_FLAG));

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign ch_pop[n]      = reg_en && !reg_we && (reg_addr == AW'(ADDR_FIFO0 + n));
        assign ch_ovf_clr[n]  = wr_stat && reg_wdata[CFG_W*n + 2];
        assign ch_flag_clr[n] = wr_flag && reg_wdata[n];

        cap_chan #(.TW(TW), .DEPTH(DEPTH)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (cap_pin[n]),
            .cfg      (t_q.cfg[n]),
            .tmr_a    (tmr_a),
            .tmr_b    (tmr_b),
            .pop      (ch_pop[n]),
            .ovf_clr  (ch_ovf_clr[n]),
            .flag_clr (ch_flag_clr[n]),
            .dout     (ch_dout[n]),
            .cnt      (ch_cnt[n]),
            .ovf      (ch_ovf[n]),
            .flag     (ch_flag[n]),
            .irq      (irq[n])
        );
    end

    always_comb begin
        t_d = t_q;
        if (wr_ctrl) begin
            for (int n = 0; n < NCH; n++) begin
                t_d.cfg[n] = chan_cfg_t'(reg_wdata[CFG_W*n +: CFG_W]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(ADDR_CTRL)) begin
            for (int n = 0; n < NCH; n++) begin
                reg_rdata[CFG_W*n +: CFG_W] = t_q.cfg[n];
            end
        end else if (reg_addr == AW'(ADDR_STAT)) begin
            for (int n = 0; n < NCH; n++) begin
                reg_rdata[CFG_W*n +: CW]  = ch_cnt[n];
                reg_rdata[CFG_W*n + 2]    = ch_ovf[n];
            end
        end else if (reg_addr == AW'(ADDR_FLAG)) begin
            reg_rdata[NCH-1:0] = ch_flag;
        end else begin
            for (int n = 0; n < NCH; n++) begin
                if (reg_addr == AW'(ADDR_FIFO0 + n)) begin
                    reg_rdata = ch_dout[n];
                end
            end
        end
    end

    p_ctrl_readback_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (t_q.cfg == $past(reg_wdata[NCH*CFG_W-1:0])));
endmodule

// File: tb/tb_ecap_top.sv
module tb_ecap_top;
    localparam int NCH = 3;
    localparam int TW  = 16;
    localparam int AW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] cap_pin;
    logic [TW-1:0]  tmr_a, tmr_b;
    logic           reg_en, reg_we;
    logic [AW-1:0]  reg_addr;
    logic [TW-1:0]  reg_wdata;
    logic [TW-1:0]  reg_rdata;
    logic [NCH-1:0] irq;

    always #4 clk = ~clk;

    ecap_top dut (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .tmr_a(tmr_a), .tmr_b(tmr_b),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [TW-1:0] mq [NCH][2];
    int            mc [NCH];
    bit            movf [NCH];
    bit            mflag [NCH];
    logic [1:0]    mmode [NCH];
    bit            mtsel [NCH];
    bit            mien [NCH];

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h exp %0h", req, got, exp);
        end
    endtask

    function automatic logic [TW-1:0] exp_stat();
        logic [TW-1:0] s = '0;
        for (int n = 0; n < NCH; n++) begin
            s[4*n +: 2] = mc[n][1:0];
            s[4*n + 2]  = movf[n];
        end
        return s;
    endfunction

    function automatic logic [TW-1:0] exp_flags();
        logic [TW-1:0] s = '0;
        for (int n = 0; n < NCH; n++) s[n] = mflag[n];
        return s;
    endfunction

    function automatic logic [NCH-1:0] exp_irq();
        logic [NCH-1:0] s;
        for (int n = 0; n < NCH; n++) s[n] = mflag[n] & mien[n];
        return s;
    endfunction

    function automatic bit edge_hit(input logic [1:0] mode, input logic lvl);
        case (mode)
            2'b01:   return lvl;
            2'b10:   return !lvl;
            2'b11:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_cap(input int n, input logic [TW-1:0] v);
        if (mc[n] == 2) begin
            mq[n][0] = mq[n][1];
            mq[n][1] = v;
            movf[n]  = 1'b1;
        end else begin
            mq[n][mc[n]] = v;
            mc[n]++;
        end
        mflag[n] = 1'b1;
    endtask

    task automatic peek(input int a, output logic [TW-1:0] d);
        reg_addr = AW'(a);
        #1 d = reg_rdata;
    endtask

    task automatic rd(input int a, output logic [TW-1:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = AW'(a);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_en = 1'b0;
    endtask

    task automatic wr(input int a, input logic [TW-1:0] d);
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [TW-1:0] w);
        wr(0, w);
        for (int n = 0; n < NCH; n++) begin
            mmode[n] = w[4*n +: 2];
            mtsel[n] = w[4*n + 2];
            mien[n]  = w[4*n + 3];
        end
    endtask

    task automatic toggle(input int n);
        logic [TW-1:0] v;
        @(negedge clk);
        tmr_a = TW'($urandom);
        tmr_b = TW'($urandom);
        cap_pin[n] = ~cap_pin[n];
        v = mtsel[n] ? tmr_b : tmr_a;
        repeat (6) @(negedge clk);
        if (edge_hit(mmode[n], cap_pin[n])) model_cap(n, v);
    endtask

    task automatic rd_fifo_chk(input int n, input string req);
        logic [TW-1:0] d, e;
        e = (mc[n] > 0) ? mq[n][0] : '0;
        rd(3 + n, d);
        if (mc[n] > 0) begin
            mq[n][0] = mq[n][1];
            mc[n]--;
        end
        chk(req, d, e);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [TW-1:0] d, w;
        void'($urandom(32'h5eed_0c4b));
        cap_pin = '0; tmr_a = '0; tmr_b = '0;
        reg_en = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        for (int n = 0; n < NCH; n++) begin
            mc[n] = 0; movf[n] = 0; mflag[n] = 0; mmode[n] = 0; mtsel[n] = 0; mien[n] = 0;
            mq[n][0] = '0; mq[n][1] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(0, d); chk("R1 ctrl after reset", d, 0);
        peek(1, d); chk("R1 status after reset", d, 0);
        peek(2, d); chk("R1 flags after reset", d, 0);
        chk("R1 irq after reset", irq, 0);
        rd_fifo_chk(0, "R1 empty fifo read");

        // R3 latency: ch0 rising, irq enabled, timer A
        wr_ctrl(16'h0009);
        @(negedge clk);
        tmr_a = 16'h1111; tmr_b = 16'h2222;
        cap_pin[0] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        peek(1, d); chk("R3 no capture after third edge", d, exp_stat());
        @(posedge clk);
        @(negedge clk);
        model_cap(0, 16'h1111);
        peek(1, d); chk("R3 capture after fourth edge", d, exp_stat());
        chk("R9 irq raised", irq, exp_irq());
        rd(2, d); chk("R9 flag set", d, exp_flags());
        wr(2, 16'h0001); mflag[0] = 0;
        chk("R9 irq cleared by w1c", irq, exp_irq());
        rd_fifo_chk(0, "R5 timer A value");

        // R2 glitch rejection on ch2 (rising)
        wr_ctrl(16'h0109);
        @(negedge clk); cap_pin[2] = 1'b1;
        @(negedge clk); cap_pin[2] = 1'b0;
        repeat (6) @(negedge clk);
        peek(1, d); chk("R2 one-cycle pulse ignored", d, exp_stat());
        @(negedge clk); tmr_a = 16'h3333; cap_pin[2] = 1'b1;
        @(negedge clk);
        @(negedge clk); cap_pin[2] = 1'b0;
        repeat (6) @(negedge clk);
        model_cap(2, 16'h3333);
        peek(1, d); chk("R2 two-cycle pulse captured", d, exp_stat());
        rd_fifo_chk(2, "R2 captured value");

        // R4 falling mode on ch0 (pin currently high)
        wr_ctrl(16'h010A);
        toggle(0);
        peek(1, d); chk("R4 falling edge captured", d, exp_stat());
        rd_fifo_chk(0, "R4 falling value");

        // R5 / R7 / R8: ch1 both edges on timer B, three captures
        wr_ctrl(16'h017A);
        toggle(1); toggle(1); toggle(1);
        peek(1, d); chk("R7 overflow status", d, exp_stat());
        chk("R10 other channels untouched", {mc[0], mc[2]}, 64'h0);
        rd_fifo_chk(1, "R7 second capture kept");
        rd_fifo_chk(1, "R5 timer B newest kept");
        rd_fifo_chk(1, "R6 empty read returns 0");
        peek(1, d); chk("R8 overflow stays until cleared", d, exp_stat());
        wr(1, 16'h0040); movf[1] = 0;
        peek(1, d); chk("R8 overflow cleared by w1c", d, exp_stat());

        // Random mix
        for (int it = 0; it < 400; it++) begin
            case ($urandom_range(0, 5))
                0: begin
                    w = TW'($urandom) & 16'h0FFF;
                    wr_ctrl(w);
                    peek(0, d); chk("R4 ctrl readback", d, w);
                end
                1, 2: begin
                    toggle($urandom_range(0, NCH - 1));
                    peek(1, d); chk("R10 status after capture", d, exp_stat());
                end
                3: rd_fifo_chk($urandom_range(0, NCH - 1), "R6 random fifo read");
                4: begin
                    rd(2, d); chk("R9 flags", d, exp_flags());
                    w = TW'($urandom);
                    wr(2, w);
                    for (int n = 0; n < NCH; n++) if (w[n]) mflag[n] = 0;
                    chk("R9 irq after clear", irq, exp_irq());
                end
                default: begin
                    w = TW'($urandom);
                    wr(1, w);
                    for (int n = 0; n < NCH; n++) if (w[4*n + 2]) movf[n] = 0;
                    peek(1, d); chk("R8 status after w1c", d, exp_stat());
                end
            endcase
        end

        for (int n = 0; n < NCH; n++) begin
            rd_fifo_chk(n, "R6 drain");
            rd_fifo_chk(n, "R6 drain");
            rd_fifo_chk(n, "R6 drain empty");
        end
        peek(1, d); chk("R8 final status", d, exp_stat());

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule